// File: doc/BRIEF.md
# CPU clock source sequencer

This block drives the select lines of a two-level clock multiplexer tree that feeds a CPU cluster, and it orders the steps of a rate change. The tree has a secondary two-input mux, which picks either the crystal oscillator or the primary PLL divided by two. It also has a primary four-input mux, which picks the secondary mux output, the primary PLL's direct output, or an alternate PLL.

A rate change starts when a target frequency in MHz is offered on a request/acknowledge handshake. The block then works through these steps:
- It moves the CPU clock onto the alternate PLL.
- It sends a programming strobe with the PLL target.
- It waits for the PLL to report lock.
- It routes the CPU clock through the path that suits the target.

The primary PLL only locks between 600 and 3000 MHz. A target from 300 up to 600 MHz is therefore produced by locking the PLL at twice the target and taking the divided-by-two branch through the secondary mux. Targets outside the supported range are refused at once. A lock that never comes ends the sequence with an error, and the CPU is left on the alternate PLL.

Top module: `cpu_clk_seq`

## Requirements
- R1: During and after reset, pri_sel = 0 and sec_sel = 0, so the CPU runs from the crystal. pll_prog_valid is low and req_ready is high.
- R2: A request is taken only in a cycle where req_ready is high. A req_valid seen while req_ready is low has no effect. req_ack is high for exactly one cycle per accepted request. req_err is only ever high together with req_ack.
- R3: A target from 601 to 3000 MHz programs the PLL to the target itself. At acknowledge it leaves pri_sel = 1 (direct PLL output) and sec_sel = 0 (crystal).
- R4: A target from 300 to 600 MHz programs the PLL to twice the target. At acknowledge it leaves sec_sel = 1 (PLL divided by two) and pri_sel = 0 (secondary mux output).
- R5: An accepted request sets pri_sel = 3 (alternate PLL) on the cycle after acceptance. pll_prog_valid is high for exactly one cycle, one cycle after that. pri_sel stays 3 until a qualified lock is seen.
- R6: A target below 300 or above 3000 MHz is acknowledged on the cycle after the request, with req_err high. No programming strobe is issued and neither select changes.
- R7: pll_lock passes through LOCK_SYNC flip-flops. It is ignored during the first LOCK_SYNC+1 cycles of the wait, so a lock left over from the previous rate cannot end the wait.
- R8: If no qualified lock arrives within LOCK_TIMEOUT wait cycles, the request is acknowledged with req_err high and pri_sel stays 3. A lock qualified in the last permitted cycle wins over the timeout.
- R9: sec_sel changes only on a clock edge before which pri_sel was not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rate change request |
| req_mhz | input | FREQ_W | Requested CPU frequency in MHz |
| req_ready | output | 1 | High while a request can be accepted |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Error qualifier of req_ack (refused or lock timeout) |
| pll_prog_valid | output | 1 | One-cycle PLL programming strobe |
| pll_prog_mhz | output | FREQ_W | PLL frequency to program, valid with the strobe |
| pll_lock | input | 1 | Primary PLL lock indication, asynchronous |
| sec_sel | output | 1 | Secondary mux select: 0 crystal, 1 PLL/2 |
| pri_sel | output | 2 | Primary mux select: 0 secondary, 1 PLL direct, 3 alternate PLL |

## Verification
Two events can fall on the same clock edge: a qualified lock arriving and the wait window running out. The PLL stub's lock delay is set so that the synchronised lock first becomes usable exactly on the last permitted wait cycle, and then one cycle later. The first case must finish on the direct path with no error. The second must end with req_err and the CPU still parked on the alternate PLL. A second overlap is a new req_valid that lands in the acknowledge cycle or during a sequence. The behavioural model compared every cycle must show it has no effect at all.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK_ALT,
    ST_PROGRAM,
    ST_WAIT_LOCK,
    ST_SELECT_PATH,
    ST_DONE
  } seq_state_e;

  // primary mux input codes
  localparam logic [1:0] PSEL_SECONDARY = 2'd0;
  localparam logic [1:0] PSEL_PLL_DIRECT = 2'd1;
  localparam logic [1:0] PSEL_ALT_PLL    = 2'd3;

  // secondary mux input codes
  localparam logic SSEL_XTAL     = 1'b0;
  localparam logic SSEL_PLL_HALF = 1'b1;

endpackage

// File: rtl/clk_seq_classify.sv
module clk_seq_classify #(
  parameter int FREQ_W    = 12,
  parameter int F_LOW_MIN = 300,
  parameter int F_VCO_MIN = 600,
  parameter int F_VCO_MAX = 3000
) (
  input  logic [FREQ_W-1:0] req_mhz,
  output logic              in_range,
  output logic              half_band,
  output logic [FREQ_W-1:0] pll_mhz
);

  localparam logic [FREQ_W-1:0] LOW_MIN = FREQ_W'(F_LOW_MIN);
  localparam logic [FREQ_W-1:0] VCO_MIN = FREQ_W'(F_VCO_MIN);
  localparam logic [FREQ_W-1:0] VCO_MAX = FREQ_W'(F_VCO_MAX);

  always_comb begin
    in_range  = (req_mhz >= LOW_MIN) && (req_mhz <= VCO_MAX);
    half_band = (req_mhz <= VCO_MIN);
    // below the VCO floor the PLL runs at twice the target
    pll_mhz   = half_band ? {req_mhz[FREQ_W-2:0], 1'b0} : req_mhz;
  end

endmodule

// File: rtl/clk_seq_lock_wait.sv
module clk_seq_lock_wait #(
  parameter int TIMEOUT     = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  input  logic lock_raw,
  output logic locked,
  output logic expired
);

  localparam int BLANK = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             lock_s;
  logic [CNT_W-1:0] cnt;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign lock_s = lock_raw;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '0;
        end else begin
          sh[0] <= lock_raw;
          for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign lock_s = sh[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (active && (cnt != LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // lock is trusted only after the stale value has left the synchroniser
  assign locked  = active && lock_s && (cnt >= CNT_W'(BLANK));
  assign expired = active && !locked && (cnt == LAST);

endmodule

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq
  import clk_seq_pkg::*;
#(
  parameter int FREQ_W       = 12,
  parameter int F_LOW_MIN    = 300,
  parameter int F_VCO_MIN    = 600,
  parameter int F_VCO_MAX    = 3000,
  parameter int LOCK_TIMEOUT = 256,
  parameter int LOCK_SYNC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [FREQ_W-1:0] req_mhz,
  output logic              req_ready,
  output logic              req_ack,
  output logic              req_err,
  output logic              pll_prog_valid,
  output logic [FREQ_W-1:0] pll_prog_mhz,
  input  logic              pll_lock,
  output logic              sec_sel,
  output logic [1:0]        pri_sel
);

  seq_state_e        state;
  logic              in_range;
  logic              half_band;
  logic [FREQ_W-1:0] cls_pll_mhz;
  logic [FREQ_W-1:0] tgt_pll_q;
  logic              half_q;
  logic              err_q;
  logic              lw_locked;
  logic              lw_expired;

  clk_seq_classify #(
    .FREQ_W   (FREQ_W),
    .F_LOW_MIN(F_LOW_MIN),
    .F_VCO_MIN(F_VCO_MIN),
    .F_VCO_MAX(F_VCO_MAX)
  ) u_classify (
    .req_mhz  (req_mhz),
    .in_range (in_range),
    .half_band(half_band),
    .pll_mhz  (cls_pll_mhz)
  );

  clk_seq_lock_wait #(
    .TIMEOUT    (LOCK_TIMEOUT),
    .SYNC_STAGES(LOCK_SYNC)
  ) u_lock_wait (
    .clk     (clk),
    .rst     (rst),
    .start   (state == ST_PROGRAM),
    .active  (state == ST_WAIT_LOCK),
    .lock_raw(pll_lock),
    .locked  (lw_locked),
    .expired (lw_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      pri_sel        <= PSEL_SECONDARY;
      sec_sel        <= SSEL_XTAL;
      pll_prog_valid <= 1'b0;
      pll_prog_mhz   <= '0;
      tgt_pll_q      <= '0;
      half_q         <= 1'b0;
      err_q          <= 1'b0;
    end else begin
      pll_prog_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (in_range) begin
              tgt_pll_q <= cls_pll_mhz;
              half_q    <= half_band;
              err_q     <= 1'b0;
              state     <= ST_PARK_ALT;
            end else begin
              err_q <= 1'b1;
              state <= ST_DONE;
            end
          end
        end
        ST_PARK_ALT: begin
          pri_sel <= PSEL_ALT_PLL;
          state   <= ST_PROGRAM;
        end
        ST_PROGRAM: begin
          pll_prog_valid <= 1'b1;
          pll_prog_mhz   <= tgt_pll_q;
          state          <= ST_WAIT_LOCK;
        end
        ST_WAIT_LOCK: begin
          if (lw_locked) begin
            // primary mux sits on the alternate PLL here, so this is safe
            sec_sel <= half_q ? SSEL_PLL_HALF : SSEL_XTAL;
            state   <= ST_SELECT_PATH;
          end else if (lw_expired) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_SELECT_PATH: begin
          pri_sel <= half_q ? PSEL_SECONDARY : PSEL_PLL_DIRECT;
          state   <= ST_DONE;
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign req_ack   = (state == ST_DONE);
  assign req_err   = (state == ST_DONE) && err_q;

endmodule

// File: rtl/cpu_clk_seq_chk.sv
module cpu_clk_seq_chk #(
  parameter int FREQ_W    = 12,
  parameter int F_LOW_MIN = 300,
  parameter int F_VCO_MAX = 3000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [FREQ_W-1:0] req_mhz,
  input logic              req_ready,
  input logic              req_ack,
  input logic              req_err,
  input logic              pll_prog_valid,
  input logic              sec_sel,
  input logic [1:0]        pri_sel
);

  localparam logic [FREQ_W-1:0] LO = FREQ_W'(F_LOW_MIN);
  localparam logic [FREQ_W-1:0] HI = FREQ_W'(F_VCO_MAX);

  // R1
  a_r1_reset_crystal: assert property (@(posedge clk)
    rst |=> (pri_sel == 2'd0) && !sec_sel && !pll_prog_valid && req_ready);

  // R2
  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R2
  a_r2_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    req_err |-> req_ack);

  // R4
  a_r4_half_path: assert property (@(posedge clk) disable iff (rst)
    (req_ack && !req_err && (pri_sel == 2'd0)) |-> sec_sel);

  // R5
  a_r5_prog_parked: assert property (@(posedge clk) disable iff (rst)
    pll_prog_valid |-> (pri_sel == 2'd3));

  // R5
  a_r5_prog_single: assert property (@(posedge clk) disable iff (rst)
    pll_prog_valid |=> !pll_prog_valid);

  // R6
  a_r6_reject_keeps_sel: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && ((req_mhz < LO) || (req_mhz > HI)))
      |=> (req_ack && req_err && $stable(pri_sel) && $stable(sec_sel)));

  // R3 / R4
  a_r3_success_leaves_alt: assert property (@(posedge clk) disable iff (rst)
    (req_ack && !req_err && !$past(req_ready)) |-> (pri_sel != 2'd3));

  // R9
  a_r9_sec_switch_safe: assert property (@(posedge clk) disable iff (rst)
    !$stable(sec_sel) |-> ($past(pri_sel) != 2'd0));

endmodule

bind cpu_clk_seq cpu_clk_seq_chk #(
  .FREQ_W   (FREQ_W),
  .F_LOW_MIN(F_LOW_MIN),
  .F_VCO_MAX(F_VCO_MAX)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_mhz       (req_mhz),
  .req_ready     (req_ready),
  .req_ack       (req_ack),
  .req_err       (req_err),
  .pll_prog_valid(pll_prog_valid),
  .sec_sel       (sec_sel),
  .pri_sel       (pri_sel)
);

// File: tb/tb_cpu_clk_seq.sv
module tb_cpu_clk_seq;

  localparam int FW  = 12;
  localparam int TMO = 20;
  localparam int SYN = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [FW-1:0] req_mhz = '0;
  logic          pll_lock = 1'b1;
  logic          req_ready, req_ack, req_err, pll_prog_valid, sec_sel;
  logic [FW-1:0] pll_prog_mhz;
  logic [1:0]    pri_sel;

  always #5 clk = ~clk;

  cpu_clk_seq #(
    .FREQ_W(FW), .LOCK_TIMEOUT(TMO), .LOCK_SYNC(SYN)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mhz(req_mhz),
    .req_ready(req_ready), .req_ack(req_ack), .req_err(req_err),
    .pll_prog_valid(pll_prog_valid), .pll_prog_mhz(pll_prog_mhz),
    .pll_lock(pll_lock), .sec_sel(sec_sel), .pri_sel(pri_sel)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // PLL stub: loses lock on a strobe, regains it lock_delay cycles later
  int lock_delay = 4;
  int lk_cnt = 0;
  always @(posedge clk) begin
    if (pll_prog_valid) begin
      pll_lock <= 1'b0;
      lk_cnt = 0;
    end else if (!pll_lock && lock_delay >= 0) begin
      lk_cnt++;
      if (lk_cnt >= lock_delay) pll_lock <= 1'b1;
    end
  end

  // behavioural reference model
  int ph = 0, wk = 0, m_tgt = 0, m_pmhz = 0, m_pri = 0, m_sec = 0;
  bit m_half = 0, m_err = 0, m_pv = 0;
  bit lk_hist[$];

  always @(posedge clk) begin
    int f;
    bit ls;
    if (rst) begin
      ph = 0; wk = 0; m_pri = 0; m_sec = 0; m_pv = 0; m_err = 0; m_pmhz = 0;
      lk_hist.delete();
      for (int i = 0; i < SYN; i++) lk_hist.push_back(1'b0);
    end else begin
      if (SYN == 0) ls = pll_lock;
      else begin
        ls = lk_hist.pop_front();
        lk_hist.push_back(pll_lock);
      end
      m_pv = 0;
      case (ph)
        0: if (req_valid) begin
             f = int'(req_mhz);
             if (f < 300 || f > 3000) begin m_err = 1; ph = 5; end
             else begin
               m_half = (f <= 600);
               m_tgt = m_half ? 2 * f : f;
               m_err = 0; ph = 1;
             end
           end
        1: begin m_pri = 3; ph = 2; end
        2: begin m_pv = 1; m_pmhz = m_tgt; wk = 0; ph = 3; end
        3: if (ls && wk >= SYN + 1) begin m_sec = m_half ? 1 : 0; ph = 4; end
           else if (wk == TMO - 1) begin m_err = 1; ph = 5; end
           else wk++;
        4: begin m_pri = m_half ? 0 : 1; ph = 5; end
        default: ph = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  int last_prog = -1;
  int strobes = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(pri_sel == 2'(m_pri), "R5", "pri_sel", int'(pri_sel), m_pri);
      chk(sec_sel == 1'(m_sec), "R4", "sec_sel", int'(sec_sel), m_sec);
      chk(req_ack == (ph == 5), "R2", "req_ack", int'(req_ack), int'(ph == 5));
      chk(req_err == (ph == 5 && m_err), "R8", "req_err", int'(req_err),
          int'(ph == 5 && m_err));
      chk(req_ready == (ph == 0), "R2", "req_ready", int'(req_ready), int'(ph == 0));
      chk(pll_prog_valid == m_pv, "R5", "prog_valid", int'(pll_prog_valid), int'(m_pv));
      if (m_pv) chk(int'(pll_prog_mhz) == m_pmhz, "R3", "prog_mhz",
                    int'(pll_prog_mhz), m_pmhz);
      if (pll_prog_valid) begin last_prog = int'(pll_prog_mhz); strobes++; end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_ack();
    for (int i = 0; i < 200; i++) begin
      if (req_ack) return;
      @(negedge clk);
    end
    chk(1'b0, "R2", "ack timeout", 0, 1);
  endtask

  task automatic do_req(input int f, input int dly);
    @(negedge clk);
    req_mhz = FW'(f);
    req_valid = 1'b1;
    lock_delay = dly;
    @(negedge clk);
    req_valid = 1'b0;
    wait_ack();
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1: state held by reset
    chk(pri_sel == 2'd0, "R1", "reset pri_sel", int'(pri_sel), 0);
    chk(sec_sel == 1'b0, "R1", "reset sec_sel", int'(sec_sel), 0);
    chk(!pll_prog_valid, "R1", "reset strobe", int'(pll_prog_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);

    // R3: direct band
    do_req(1200, 5);
    chk(!req_err && pri_sel == 2'd1 && !sec_sel, "R3", "1200 path",
        int'(pri_sel), 1);
    chk(last_prog == 1200, "R3", "1200 pll", last_prog, 1200);

    // R4: halved band
    do_req(450, 3);
    chk(!req_err && pri_sel == 2'd0 && sec_sel, "R4", "450 path", int'(pri_sel), 0);
    chk(last_prog == 900, "R4", "450 pll", last_prog, 900);

    do_req(600, 2);
    chk(sec_sel && pri_sel == 2'd0 && last_prog == 1200, "R4", "600 edge",
        last_prog, 1200);
    do_req(300, 2);
    chk(last_prog == 600 && sec_sel, "R4", "300 edge", last_prog, 600);
    do_req(601, 2);
    chk(last_prog == 601 && pri_sel == 2'd1 && !sec_sel, "R3", "601 edge",
        last_prog, 601);
    do_req(3000, 2);
    chk(last_prog == 3000 && !req_err, "R3", "3000 edge", last_prog, 3000);

    // R6: refused targets
    s0 = strobes;
    do_req(299, 2);
    chk(req_err && pri_sel == 2'd1, "R6", "299 refused", int'(req_err), 1);
    do_req(3001, 2);
    chk(req_err && pri_sel == 2'd1 && strobes == s0, "R6", "3001 no strobe",
        strobes, s0);

    // R8: no lock at all
    do_req(800, -1);
    chk(req_err && pri_sel == 2'd3, "R8", "timeout parks", int'(pri_sel), 3);

    // R7 / R8: lock usable on the last permitted cycle wins
    do_req(800, 16);
    chk(!req_err && pri_sel == 2'd1, "R8", "lock at limit", int'(req_err), 0);
    do_req(800, 17);
    chk(req_err && pri_sel == 2'd3, "R8", "lock past limit", int'(req_err), 1);

    // R7: stale lock from the previous rate is ignored
    do_req(500, 0);
    chk(!req_err && sec_sel && pri_sel == 2'd0, "R7", "fresh lock", int'(sec_sel), 1);

    // R2: request during a sequence and in the ack cycle is ignored
    @(negedge clk);
    req_mhz = FW'(1500); req_valid = 1'b1; lock_delay = 6;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_mhz = FW'(400); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_ack();
    chk(last_prog == 1500 && pri_sel == 2'd1, "R2", "busy request ignored",
        last_prog, 1500);
    req_mhz = FW'(100); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ack && req_ready, "R2", "ack-cycle request ignored", int'(req_ack), 0);

    // R9: high band then low band then high band
    do_req(2000, 1);
    do_req(350, 1);
    chk(sec_sel && last_prog == 700, "R9", "low after high", last_prog, 700);
    do_req(900, 1);
    chk(!sec_sel && pri_sel == 2'd1, "R9", "high after low", int'(sec_sel), 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule